// File: doc/BRIEF.md
# External Interrupt Channel Bank

This block holds a parameterized number of external interrupt channels. Each channel takes an asynchronous input pin and brings it into the clock domain through a two-stage synchronizer. A per-channel option passes the synchronized value through a 2-of-3 majority vote. The channel then looks for either a high level or a rising edge. When that condition is seen on an enabled channel, the channel's pending bit is set. The pending bit stays set until software clears it, or until the channel is turned off.

Software drives the bank through a plain register port, with a single write strobe and a combinational read. Turning channels on and off uses separate write-one registers, and so does setting and clearing the mask. A write of zero bits leaves the state alone. The mask only gates the per-channel interrupt lines. A pending bit that is masked still raises the wake output. This lets a sleeping system be woken by a source whose interrupt line is gated off.

Register offsets (4-bit address, one bit per channel in each):

- 0x0: write-one turn-on.
- 0x1: write-one turn-off.
- 0x2: enabled-state readback.
- 0x3: write-one mask set.
- 0x4: write-one mask clear.
- 0x5: mask readback.
- 0x6: pending readback.
- 0x7: write-one pending clear.
- 0x8: filter select (read/write).
- 0x9: detect select (read/write, 1 = rising edge, 0 = high level).

Top module: `eic_bank`

## Requirements
- R1: A write to offset 0x0 sets every enabled-state bit that is one in the data. Zero bits, and writes of zero to offset 0x1, leave the enabled state unchanged. The enabled state reads back at offset 0x2.
- R2: A write to offset 0x1 clears the enabled-state bit and the pending bit of every channel whose data bit is one, on the same clock edge.
- R3: While a channel is off, its pending bit reads zero, whatever its pin does.
- R4: A write of one to a channel's bit at offset 0x7 clears its pending bit on that edge. A clear wins over a detection in the same cycle.
- R5: In level mode with the filter off, a pin that rises just after an edge sets pending on the third rising clock edge. If the level is still present after a clear, pending sets again on the next edge.
- R6: With bit one at offset 0x9 (edge mode, readable there), pending sets once per low-to-high transition of the synchronized pin. It stays clear after a clear while the pin remains high.
- R7: With bit one at offset 0x8, a pin high for a single clock cycle never sets pending. A held level sets pending on the fourth edge, one later than without the filter.
- R8: With the filter off, a pin high for a single clock cycle is captured as pending.
- R9: Offsets 0x3 and 0x4 set and clear mask bits (write-one), and 0x5 reads them back. Each irq_o bit is high only when that channel is pending and masked in.
- R10: wake_o is high exactly when any pending bit is set, masked or not.
- R11: After reset, every register reads zero and irq_o and wake_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Synchronization and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NCH | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write offset |
| wr_data | input | NCH | Register write data, one bit per channel |
| rd_addr | input | 4 | Register read offset |
| rd_data | output | NCH | Combinational read data |
| irq_o | output | NCH | Per-channel masked interrupt lines |
| wake_o | output | 1 | OR of all pending bits |

## Verification
The hardest case to reach from the ports is the filter's rejection of a one-cycle pulse. The majority window spans three synchronized samples, so the pulse must line up with exactly one clock period. The stimulus drives the same one-period pulse on a filtered channel and an unfiltered channel at once. The pending word then shows the one channel caught and the other not. A second hard case is a clear arriving while the level is still present: the write is issued with the pin held high, and pending is sampled on the write edge and on the edge after it.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_ON_SET   = 4'h0;
  localparam logic [AW-1:0] A_OFF_SET  = 4'h1;
  localparam logic [AW-1:0] A_ON_STATE = 4'h2;
  localparam logic [AW-1:0] A_MSK_SET  = 4'h3;
  localparam logic [AW-1:0] A_MSK_CLR  = 4'h4;
  localparam logic [AW-1:0] A_MSK_ST   = 4'h5;
  localparam logic [AW-1:0] A_PEND     = 4'h6;
  localparam logic [AW-1:0] A_PEND_CLR = 4'h7;
  localparam logic [AW-1:0] A_VOTE     = 4'h8;
  localparam logic [AW-1:0] A_EDGE     = 4'h9;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, meta_n;
  logic [W-1:0] sync_q, sync_n;

  always_comb begin
    meta_n = d_i;
    sync_n = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= meta_n;
      sync_q <= sync_n;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/eic_vote.sv
module eic_vote #(
  parameter int unsigned W         = 4,
  parameter bit          FILTER_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] f_o
);
  generate
    if (FILTER_EN) begin : g_filt
      logic [W-1:0] h0_q, h1_q, h0_n, h1_n;

      always_comb begin
        h0_n = s_i;
        h1_n = h0_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          h0_q <= '0;
          h1_q <= '0;
        end else begin
          h0_q <= h0_n;
          h1_q <= h1_n;
        end
      end

      for (genvar i = 0; i < W; i++) begin : g_ch
        logic maj;
        assign maj    = (s_i[i] & h0_q[i]) | (s_i[i] & h1_q[i]) | (h0_q[i] & h1_q[i]);
        assign f_o[i] = sel_i[i] ? maj : s_i[i];
      end
    end else begin : g_bypass
      logic [W-1:0] unused_sel;
      assign unused_sel = sel_i;
      assign f_o        = s_i;
    end
  endgenerate
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  pend_i,
  output logic [W-1:0]  on_o,
  output logic [W-1:0]  msk_o,
  output logic [W-1:0]  vote_o,
  output logic [W-1:0]  edge_o,
  output logic [W-1:0]  off_p_o,
  output logic [W-1:0]  clr_p_o,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] on_q, on_n, msk_q, msk_n, vote_q, vote_n, edge_q, edge_n;
  logic [W-1:0] on_set, off_set, m_set, m_clr;
  logic         vote_we, edge_we;

  always_comb begin
    on_set  = (wr_en && wr_addr == A_ON_SET)   ? wr_data : '0;
    off_set = (wr_en && wr_addr == A_OFF_SET)  ? wr_data : '0;
    m_set   = (wr_en && wr_addr == A_MSK_SET)  ? wr_data : '0;
    m_clr   = (wr_en && wr_addr == A_MSK_CLR)  ? wr_data : '0;
    clr_p_o = (wr_en && wr_addr == A_PEND_CLR) ? wr_data : '0;
    vote_we = wr_en && (wr_addr == A_VOTE);
    edge_we = wr_en && (wr_addr == A_EDGE);
    off_p_o = off_set;

    on_n   = (on_q | on_set) & ~off_set;
    msk_n  = (msk_q | m_set) & ~m_clr;
    vote_n = vote_we ? wr_data : vote_q;
    edge_n = edge_we ? wr_data : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      msk_q  <= '0;
      vote_q <= '0;
      edge_q <= '0;
    end else begin
      on_q   <= on_n;
      msk_q  <= msk_n;
      vote_q <= vote_n;
      edge_q <= edge_n;
    end
  end

  always_comb begin
    case (rd_addr)
      A_ON_STATE: rd_data = on_q;
      A_MSK_ST:   rd_data = msk_q;
      A_PEND:     rd_data = pend_i;
      A_VOTE:     rd_data = vote_q;
      A_EDGE:     rd_data = edge_q;
      default:    rd_data = '0;
    endcase
  end

  assign on_o   = on_q;
  assign msk_o  = msk_q;
  assign vote_o = vote_q;
  assign edge_o = edge_q;
endmodule

// File: rtl/eic_detect.sv
module eic_detect #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] f_i,
  input  logic [W-1:0] on_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] off_p_i,
  input  logic [W-1:0] clr_p_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, prev_n, pend_q, pend_n, cond;

  for (genvar i = 0; i < W; i++) begin : g_ch
    always_comb begin
      cond[i] = edge_i[i] ? (f_i[i] & ~prev_q[i]) : f_i[i];
      if (!on_i[i] || off_p_i[i] || clr_p_i[i]) pend_n[i] = 1'b0;
      else if (cond[i])                          pend_n[i] = 1'b1;
      else                                       pend_n[i] = pend_q[i];
    end
  end

  assign prev_n = f_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_n;
      pend_q <= pend_n;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/eic_bank.sv
module eic_bank
  import eic_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter bit          FILTER_EN = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [NCH-1:0] rd_data,
  output logic           wake_o,
  output logic [NCH-1:0] irq_o
);
  logic           rst_m_q, rst_q_n;
  logic [NCH-1:0] s_w, f_w, on_w, msk_w, vote_w, edge_w, off_w, clr_w, pend_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_q_n <= rst_m_q;
    end
  end

  eic_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d_i(pin_i), .q_o(s_w)
  );

  eic_vote #(.W(NCH), .FILTER_EN(FILTER_EN)) u_vote (
    .clk(clk), .rst_n(rst_q_n), .s_i(s_w), .sel_i(vote_w), .f_o(f_w)
  );

  eic_regs #(.W(NCH)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .pend_i(pend_w),
    .on_o(on_w), .msk_o(msk_w), .vote_o(vote_w), .edge_o(edge_w),
    .off_p_o(off_w), .clr_p_o(clr_w), .rd_data(rd_data)
  );

  eic_detect #(.W(NCH)) u_det (
    .clk(clk), .rst_n(rst_q_n), .f_i(f_w), .on_i(on_w), .edge_i(edge_w),
    .off_p_i(off_w), .clr_p_i(clr_w), .pend_o(pend_w)
  );

  assign irq_o  = pend_w & msk_w;
  assign wake_o = |pend_w;
endmodule

// File: rtl/eic_bank_chk.sv
module eic_bank_chk
  import eic_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [NCH-1:0] wr_data,
  input logic [NCH-1:0] irq_o,
  input logic           wake_o,
  input logic [NCH-1:0] on,
  input logic [NCH-1:0] msk,
  input logic [NCH-1:0] pend
);
  p_turn_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ON_SET) |=> ((on & $past(wr_data)) == $past(wr_data)));

  p_turn_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_OFF_SET) |=> (((on | pend) & $past(wr_data)) == '0));

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~on) == '0));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_PEND_CLR) |=> ((pend & $past(wr_data)) == '0));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~(pend & msk)) == '0));

  p_wake_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (on != '0));
endmodule

bind eic_bank eic_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq_o(irq_o), .wake_o(wake_o),
  .on(on_w), .msk(msk_w), .pend(pend_w)
);

// File: tb/tb_eic_bank.sv
`timescale 1ns/10ps
module tb_eic_bank;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] pin_i;
  logic           wr_en;
  logic [3:0]     wr_addr, rd_addr;
  logic [NCH-1:0] wr_data, rd_data, irq_o;
  logic           wake_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    string      rid;
    int         kind;
    logic [3:0] addr;
    logic [3:0] m;
    logic [3:0] exp;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  eic_bank #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .wake_o(wake_o), .irq_o(irq_o)
  );

  task automatic push(string rid, int kind, logic [3:0] a, logic [3:0] m, logic [3:0] e);
    item_t it;
    it.rid = rid; it.kind = kind; it.addr = a; it.m = m; it.exp = e;
    q.push_back(it);
  endtask

  task automatic exp_rd(string rid, logic [3:0] a, logic [3:0] m, logic [3:0] e);
    push(rid, 0, a, m, e);
  endtask

  task automatic exp_irq(string rid, logic [3:0] m, logic [3:0] e);
    push(rid, 1, 4'h0, m, e);
  endtask

  task automatic exp_wake(string rid, logic e);
    push(rid, 2, 4'h0, 4'h1, {3'b0, e});
  endtask

  initial begin
    forever begin
      wait (q.size() != 0);
      #1;
      while (q.size() != 0) begin
        item_t it;
        logic [3:0] act;
        it = q.pop_front();
        rd_addr = it.addr;
        #0.1;
        case (it.kind)
          0:       act = rd_data & it.m;
          1:       act = irq_o & it.m;
          default: act = {3'b0, wake_o};
        endcase
        n_chk++;
        if (act !== (it.exp & it.m)) begin
          n_bad++;
          $display("FAIL %s kind=%0d addr=%h actual=%b expected=%b", it.rid, it.kind,
                   it.addr, act, it.exp & it.m);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_i = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R11 reset state
    exp_rd("R11", 4'h2, 4'hF, 4'h0);
    exp_rd("R11", 4'h5, 4'hF, 4'h0);
    exp_rd("R11", 4'h6, 4'hF, 4'h0);
    exp_irq("R11", 4'hF, 4'h0);
    exp_wake("R11", 1'b0);
    tick(1);

    // R1 turn-on, zero writes ignored
    wr(4'h0, 4'b0001);
    exp_rd("R1", 4'h2, 4'hF, 4'b0001);
    wr(4'h0, 4'b0000);
    wr(4'h1, 4'b0000);
    exp_rd("R1", 4'h2, 4'hF, 4'b0001);
    wr(4'h3, 4'b0001);
    exp_rd("R9", 4'h5, 4'hF, 4'b0001);

    // R5 level latency
    pin_i[0] = 1'b1;
    tick(2);
    exp_rd("R5", 4'h6, 4'b0001, 4'b0000);
    tick(1);
    exp_rd("R5", 4'h6, 4'b0001, 4'b0001);
    exp_irq("R9", 4'b0001, 4'b0001);
    exp_wake("R10", 1'b1);
    // R4 clear wins, R5 re-set while level present
    wr(4'h7, 4'b0001);
    exp_rd("R4", 4'h6, 4'b0001, 4'b0000);
    tick(1);
    exp_rd("R5", 4'h6, 4'b0001, 4'b0001);
    pin_i[0] = 1'b0;
    tick(3);
    wr(4'h7, 4'b0001);
    exp_rd("R4", 4'h6, 4'b0001, 4'b0000);
    tick(2);
    exp_rd("R4", 4'h6, 4'hF, 4'b0000);
    exp_wake("R10", 1'b0);

    // R9 mask clear, R10 wake from unmasked-out channel
    wr(4'h4, 4'b0001);
    exp_rd("R9", 4'h5, 4'hF, 4'b0000);
    wr(4'h0, 4'b0010);
    pin_i[1] = 1'b1;
    tick(3);
    exp_rd("R10", 4'h6, 4'b0010, 4'b0010);
    exp_irq("R9", 4'hF, 4'b0000);
    exp_wake("R10", 1'b1);
    // R2 turn-off clears pending, R3 held at zero
    wr(4'h1, 4'b0010);
    exp_rd("R2", 4'h6, 4'b0010, 4'b0000);
    exp_rd("R2", 4'h2, 4'b0010, 4'b0000);
    tick(3);
    exp_rd("R3", 4'h6, 4'b0010, 4'b0000);
    exp_wake("R3", 1'b0);
    pin_i[1] = 1'b0;

    // R7 pulse rejection vs R8 pulse capture
    wr(4'h0, 4'b1100);
    wr(4'h8, 4'b0100);
    exp_rd("R7", 4'h8, 4'hF, 4'b0100);
    tick(3);
    pin_i[3:2] = 2'b11;
    tick(1);
    pin_i[3:2] = 2'b00;
    tick(5);
    exp_rd("R8", 4'h6, 4'b1000, 4'b1000);
    exp_rd("R7", 4'h6, 4'b0100, 4'b0000);
    wr(4'h7, 4'b1000);
    // R7 added latency
    pin_i[2] = 1'b1;
    tick(3);
    exp_rd("R7", 4'h6, 4'b0100, 4'b0000);
    tick(1);
    exp_rd("R7", 4'h6, 4'b0100, 4'b0100);
    pin_i[2] = 1'b0;
    tick(4);
    wr(4'h1, 4'b0100);

    // R6 edge mode
    wr(4'h9, 4'b0001);
    exp_rd("R6", 4'h9, 4'hF, 4'b0001);
    wr(4'h3, 4'b0001);
    pin_i[0] = 1'b1;
    tick(3);
    exp_rd("R6", 4'h6, 4'b0001, 4'b0001);
    exp_irq("R6", 4'b0001, 4'b0001);
    wr(4'h7, 4'b0001);
    tick(3);
    exp_rd("R6", 4'h6, 4'b0001, 4'b0000);
    pin_i[0] = 1'b0;
    tick(3);
    pin_i[0] = 1'b1;
    tick(3);
    exp_rd("R6", 4'h6, 4'b0001, 4'b0001);
    tick(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule